// File: doc/BRIEF.md
# Approximate 4-2 Compressor Slice

This block is one column slice of a partial-product reduction tree. It takes four bits of equal weight (and, in two of its forms, a carry from the slice to its right) and returns a weight-1 sum bit and one or two weight-2 bits. A compile-time parameter picks the form of the slice. The exact form is built from two full adders and is the arithmetic reference. The two approximate forms give up exactness on a fixed, known set of input patterns in return for much shallower logic.

Approximate form A keeps the slice-to-slice carry pins. It passes the incoming carry straight to the carry output and clears the sum whenever that carry is set. Approximate form B has no carry pins: its carry-in is not looked at and its carry-out is held low. Its carry and sum come from two-level terms over the two input pairs (x1,x2) and (x3,x4). The block is purely combinational, so outputs follow inputs in the same cycle. A row of slices is assembled by the parent, which is why no handshake sits at this level.

Top module: `cmp42_slice`

## Requirements
- R1: With VARIANT = CMP_EXACT (0), sum + 2*carry + 2*cout equals x1+x2+x3+x4+cin for all 32 input patterns.
- R2: With VARIANT = CMP_EXACT, cout is the majority of x1, x2 and x3 and never depends on cin.
- R3: With VARIANT = CMP_APPROX_A (1), carry equals cin for every input pattern.
- R4: With VARIANT = CMP_APPROX_A, sum is 0 whenever cin = 1. When cin = 0, sum is (x1 XNOR x2) OR (x3 XNOR x4).
- R5: With VARIANT = CMP_APPROX_A, cout is (x1 OR x2) AND (x3 OR x4) for either value of cin.
- R6: With VARIANT = CMP_APPROX_A, exactly 12 of the 32 patterns give a weighted value that differs from the exact input count, and each of those differs by exactly +1 or -1.
- R7: With VARIANT = CMP_APPROX_B (2), carry is (x1 OR x2) AND (x3 OR x4) and sum is (x1 XNOR x2) OR (x3 XNOR x4). cin has no effect on any output, and cout is held at 0.
- R8: With VARIANT = CMP_APPROX_B, exactly 4 of the 16 patterns of x are wrong, each by +1 or -1. Input 0000 gives carry=0 and sum=1 (value 1). Input 1111 gives carry=1 and sum=1 (value 3).
- R9: For both approximate forms, the all-zero input (x = 0000, cin = 0) gives a wrong result: value 1 instead of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 4 | Four equal-weight input bits; bit 0 is x1, bit 3 is x4 |
| cin_i | input | 1 | Carry from the slice to the right (weight 1); ignored by form B |
| sum_o | output | 1 | Sum bit, weight 1 |
| carry_o | output | 1 | Carry bit to the next column, weight 2 |
| cout_o | output | 1 | Carry to the next slice in the row, weight 2; 0 in form B |

## Verification
In form A, a set cin both forwards onto the carry output and clears the sum in the same evaluation. At the same time, the cout term is formed from the pair products. Sweeping every x pattern with cin high shows these functions acting together. Each result is judged bit by bit against the requirement equations and, as a weighted value, against the exact count. This confirms the 12 mismatches and their +1/-1 sizes. A second concurrency is form B's cin: toggling it while x is held shows whether the ignored pin leaks into carry, sum or cout.

// File: rtl/cmp42_pkg.sv
package cmp42_pkg;
  typedef enum logic [1:0] {
    CMP_EXACT    = 2'd0,
    CMP_APPROX_A = 2'd1,
    CMP_APPROX_B = 2'd2
  } cmp_variant_e;

  localparam int unsigned CMP_NIN = 4;
  localparam int unsigned CMP_VW  = 3;
endpackage

// File: rtl/cmp42_fa.sv
module cmp42_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);
  always_comb begin
    s_o  = a_i ^ b_i ^ c_i;
    co_o = (a_i & b_i) | (c_i & (a_i ^ b_i));
  end
endmodule

// File: rtl/cmp42_exact.sv
module cmp42_exact
  import cmp42_pkg::*;
(
  input  logic [CMP_NIN-1:0] x_i,
  input  logic               cin_i,
  output logic               sum_o,
  output logic               carry_o,
  output logic               cout_o
);
  logic s_mid;

  cmp42_fa u_fa_lo (
    .a_i (x_i[0]),
    .b_i (x_i[1]),
    .c_i (x_i[2]),
    .s_o (s_mid),
    .co_o(cout_o)
  );

  cmp42_fa u_fa_hi (
    .a_i (s_mid),
    .b_i (x_i[3]),
    .c_i (cin_i),
    .s_o (sum_o),
    .co_o(carry_o)
  );
endmodule

// File: rtl/cmp42_apx_a.sv
module cmp42_apx_a
  import cmp42_pkg::*;
(
  input  logic [CMP_NIN-1:0] x_i,
  input  logic               cin_i,
  output logic               sum_o,
  output logic               carry_o,
  output logic               cout_o
);
  logic eq_lo, eq_hi;

  always_comb begin
    eq_lo   = ~(x_i[0] ^ x_i[1]);
    eq_hi   = ~(x_i[2] ^ x_i[3]);
    carry_o = cin_i;
    cout_o  = (x_i[0] | x_i[1]) & (x_i[2] | x_i[3]);
    sum_o   = ~cin_i & (eq_lo | eq_hi);
  end
endmodule

// File: rtl/cmp42_apx_b.sv
module cmp42_apx_b
  import cmp42_pkg::*;
(
  input  logic [CMP_NIN-1:0] x_i,
  output logic               sum_o,
  output logic               carry_o
);
  always_comb begin
    carry_o = (x_i[0] | x_i[1]) & (x_i[2] | x_i[3]);
    sum_o   = ~(x_i[0] ^ x_i[1]) | ~(x_i[2] ^ x_i[3]);
  end
endmodule

// File: rtl/cmp42_slice.sv
module cmp42_slice
  import cmp42_pkg::*;
#(
  parameter cmp_variant_e VARIANT = CMP_EXACT
) (
  input  logic [3:0] x_i,
  input  logic       cin_i,
  output logic       sum_o,
  output logic       carry_o,
  output logic       cout_o
);
  logic [CMP_VW-1:0] cnt_x, cnt_all, wval;

  generate
    if (VARIANT == CMP_APPROX_A) begin : g_apx_a
      cmp42_apx_a u_core (
        .x_i    (x_i),
        .cin_i  (cin_i),
        .sum_o  (sum_o),
        .carry_o(carry_o),
        .cout_o (cout_o)
      );
    end else if (VARIANT == CMP_APPROX_B) begin : g_apx_b
      cmp42_apx_b u_core (
        .x_i    (x_i),
        .sum_o  (sum_o),
        .carry_o(carry_o)
      );
      assign cout_o = 1'b0;
    end else begin : g_exact
      cmp42_exact u_core (
        .x_i    (x_i),
        .cin_i  (cin_i),
        .sum_o  (sum_o),
        .carry_o(carry_o),
        .cout_o (cout_o)
      );
    end
  endgenerate

  always_comb begin
    cnt_x   = {2'b00, x_i[0]} + {2'b00, x_i[1]} + {2'b00, x_i[2]} + {2'b00, x_i[3]};
    cnt_all = cnt_x + {2'b00, cin_i};
    wval    = {2'b00, sum_o} + {1'b0, carry_o, 1'b0} + {1'b0, cout_o, 1'b0};
  end

  // Checks comparing the weighted output value of the core against the input count
  always_comb begin
    case (VARIANT)
      CMP_APPROX_A: begin
        assert_err_bound_R6: assert ((wval == cnt_all) || (wval == cnt_all + 3'd1) ||
                                     (wval + 3'd1 == cnt_all))
          else $error("approx A error larger than one");
        assert_cin_even_R4: assert (!cin_i || !wval[0])
          else $error("approx A odd value with carry in set");
      end
      CMP_APPROX_B: begin
        assert_err_bound_R8: assert ((wval == cnt_x) || (wval == cnt_x + 3'd1) ||
                                     (wval + 3'd1 == cnt_x))
          else $error("approx B error larger than one");
        assert_zero_wrong_R9: assert ((x_i != 4'b0000) || (wval == 3'd1))
          else $error("approx B zero input value");
      end
      default: begin
        assert_exact_sum_R1: assert (wval == cnt_all)
          else $error("exact value mismatch");
      end
    endcase
  end
endmodule

// File: tb/cmp42_slice_tb.sv
module cmp42_slice_tb;
  import cmp42_pkg::*;

  logic       clk = 1'b0;
  logic [3:0] x   = 4'b0000;
  logic       cin = 1'b0;
  logic       e_sum, e_carry, e_cout;
  logic       a_sum, a_carry, a_cout;
  logic       b_sum, b_carry, b_cout;
  int         n_tests = 0;
  int         n_fail  = 0;
  bit         done    = 1'b0;

  always #5 clk = ~clk;

  cmp42_slice #(.VARIANT(CMP_APPROX_A)) u_dut (
    .x_i(x), .cin_i(cin), .sum_o(a_sum), .carry_o(a_carry), .cout_o(a_cout));
  cmp42_slice #(.VARIANT(CMP_EXACT)) u_dut_exact (
    .x_i(x), .cin_i(cin), .sum_o(e_sum), .carry_o(e_carry), .cout_o(e_cout));
  cmp42_slice #(.VARIANT(CMP_APPROX_B)) u_dut_b (
    .x_i(x), .cin_i(cin), .sum_o(b_sum), .carry_o(b_carry), .cout_o(b_cout));

  function automatic int f_count(input logic [3:0] v, input logic c);
    return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]) + int'(c);
  endfunction

  function automatic logic [2:0] f_apx_a(input logic [3:0] v, input logic c);
    logic co, s;
    co = (v[0] | v[1]) & (v[2] | v[3]);
    s  = c ? 1'b0 : ((v[0] ~^ v[1]) | (v[2] ~^ v[3]));
    return {co, c, s};
  endfunction

  function automatic logic [1:0] f_apx_b(input logic [3:0] v);
    return {(v[0] | v[1]) & (v[2] | v[3]), (v[0] ~^ v[1]) | (v[2] ~^ v[3])};
  endfunction

  function automatic logic f_maj(input logic [3:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s x=%b cin=%b actual=%0d expected=%0d", tag, x, cin, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] v, input logic c);
    @(negedge clk);
    x   = v;
    cin = c;
    #2;
  endtask

  task automatic check_all();
    logic [2:0] ea;
    logic [1:0] eb;
    ea = f_apx_a(x, cin);
    eb = f_apx_b(x);
    chk("R1 exact value", int'(e_sum) + 2 * int'(e_carry) + 2 * int'(e_cout), f_count(x, cin));
    chk("R2 exact cout", int'(e_cout), int'(f_maj(x)));
    chk("R3 A carry", int'(a_carry), int'(ea[1]));
    chk("R4 A sum", int'(a_sum), int'(ea[0]));
    chk("R5 A cout", int'(a_cout), int'(ea[2]));
    chk("R7 B bits", int'({b_cout, b_carry, b_sum}), int'({1'b0, eb}));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    int mis_e, mis_a, mis_b, bad_step_a, bad_step_b, d;
    logic [3:0] rv;
    logic       rc;
    mis_e = 0; mis_a = 0; mis_b = 0; bad_step_a = 0; bad_step_b = 0;
    void'($urandom(32'h00C0_FFEE));

    // Idle state: all inputs low (R9 for both approximate forms)
    apply(4'b0000, 1'b0);
    chk("R9 A zero value", int'(a_sum) + 2 * int'(a_carry) + 2 * int'(a_cout), 1);
    chk("R9 B zero value", int'(b_sum) + 2 * int'(b_carry), 1);
    chk("R1 exact zero", int'({e_cout, e_carry, e_sum}), 0);

    // Exhaustive sweep of all 32 patterns
    for (int p = 0; p < 32; p++) begin
      apply(p[3:0], p[4]);
      check_all();
      d = int'(e_sum) + 2 * int'(e_carry) + 2 * int'(e_cout) - f_count(x, cin);
      if (d != 0) mis_e++;
      d = int'(a_sum) + 2 * int'(a_carry) + 2 * int'(a_cout) - f_count(x, cin);
      if (d != 0) mis_a++;
      if (d > 1 || d < -1) bad_step_a++;
      if (!cin) begin
        d = int'(b_sum) + 2 * int'(b_carry) - f_count(x, 1'b0);
        if (d != 0) mis_b++;
        if (d > 1 || d < -1) bad_step_b++;
      end
    end
    chk("R1 exact mismatches", mis_e, 0);
    chk("R6 A mismatches", mis_a, 12);
    chk("R6 A error size", bad_step_a, 0);
    chk("R8 B mismatches", mis_b, 4);
    chk("R8 B error size", bad_step_b, 0);

    // Directed corners for form B
    apply(4'b0000, 1'b0);
    chk("R8 B 0000", int'({b_carry, b_sum}), 1);
    apply(4'b1111, 1'b0);
    chk("R8 B 1111", int'({b_carry, b_sum}), 3);
    apply(4'b1111, 1'b1);
    chk("R7 B cin ignored", int'({b_cout, b_carry, b_sum}), 3);

    // cin toggled with x held: exact cout and form B unaffected
    for (int p = 0; p < 16; p++) begin
      logic e_co0;
      logic [2:0] b0;
      apply(p[3:0], 1'b0);
      e_co0 = e_cout;
      b0 = {b_cout, b_carry, b_sum};
      apply(p[3:0], 1'b1);
      chk("R2 exact cout vs cin", int'(e_cout), int'(e_co0));
      chk("R7 B vs cin", int'({b_cout, b_carry, b_sum}), int'(b0));
    end

    // Random patterns with a fixed seed
    for (int i = 0; i < 200; i++) begin
      rv = 4'($urandom_range(0, 15));
      rc = 1'($urandom_range(0, 1));
      apply(rv, rc);
      check_all();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule